// File: doc/BRIEF.md
# Vector String Element Finder

This block searches two 128-bit vector operands for the first element position that meets a condition. The condition is either "the two elements are equal" or "the two elements differ". The element size is 8, 16 or 32 bits. The block can also stop the scan at the first element of the first operand whose bytes are all zero. This stop is used to handle strings that end in a null character.

The block starts at the leftmost element and returns the byte offset of whichever event it meets first: a qualifying element or a terminator. It also returns a condition code that tells which event was found. When the scan finds nothing, the offset is 16 and the code says "none".

A request is presented with a one-cycle strobe together with its operands and mode inputs. The result appears on the next clock with its own valid flag. It stays on the outputs until another request replaces it. A request may be issued on every cycle.

Top module: `vec_elem_scan`

## Requirements
- R1: Byte index k of an operand is bits [127-8k : 120-8k], so byte 0 is the leftmost byte. Elements are scanned in order of rising byte index, and `res_idx` is the byte index of the first byte of the reported element.
- R2: `elem_sz` selects the element size: 2'b00 is 8 bits, 2'b01 is 16 bits, and 2'b10 or 2'b11 is 32 bits. Elements begin only at byte indices that are multiples of the element size, so bytes that match across an element boundary never qualify.
- R3: With `want_diff`=0, an element qualifies when all of its bytes in `vec_a` equal the same bytes in `vec_b`. With `want_diff`=1, an element qualifies when at least one of its bytes differs.
- R4: With `stop_on_nul`=1, an element of `vec_a` whose bytes are all zero is a terminator. With `stop_on_nul`=0, zero elements have no special meaning. Zero elements in `vec_b` never terminate the scan.
- R5: When no element qualifies and no terminator is seen, `res_idx` is 16 and `res_cc` is 3.
- R6: When a qualifying element comes first, `res_cc` is 1. When a terminator comes first, `res_cc` is 0. When the same element is both a terminator and qualifying, `res_cc` is 0. In every case `res_idx` is that element's byte index, and `res_cc` is never 2.
- R7: `res_valid` is high in the cycle after each cycle in which `req_valid` is high, and low in the cycle after each cycle in which `req_valid` is low. Back-to-back requests each give their own result.
- R8: After reset, `res_valid` is 0, `res_idx` is 16 and `res_cc` is 3. When no request arrives, `res_idx` and `res_cc` keep their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request strobe; operands and modes are captured on this cycle |
| vec_a | input | 128 | First operand; its zero elements can terminate the scan |
| vec_b | input | 128 | Second operand |
| elem_sz | input | 2 | Element size select |
| want_diff | input | 1 | 0 searches for equal elements, 1 searches for differing elements |
| stop_on_nul | input | 1 | 1 enables the zero-terminator stop |
| res_valid | output | 1 | Result valid, one cycle after the request |
| res_idx | output | 5 | Byte index of the reported element, or 16 |
| res_cc | output | 2 | 0 terminator first, 1 match first, 3 nothing found |

## Verification
The control holds only two states, so a wrong state shows on the very next cycle as `res_valid` out of step with the strobe of the cycle before. Faults in the element merge or in the priority encoders show in that same result cycle. Typical symptoms are an offset that is not a multiple of the element size, an offset past a terminator, a code of 0 reported while the stop is disabled, or the wrong winner when a match and a terminator fall on the same element. The directed cases place these events at known byte positions. A short run of scattered operands is compared against a behavioural model that is built from the requirements.

// File: rtl/vscan_pkg.sv
package vscan_pkg;

    typedef enum logic [1:0] {
        ESZ_BYTE = 2'b00,
        ESZ_HALF = 2'b01,
        ESZ_WORD = 2'b10,
        ESZ_WALT = 2'b11
    } esz_t;

    typedef enum logic [1:0] {
        CC_NUL   = 2'd0,
        CC_MATCH = 2'd1,
        CC_NONE  = 2'd3
    } scan_cc_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SHOW = 1'b1
    } scan_st_t;

endpackage

// File: rtl/vscan_byte_lane.sv
module vscan_byte_lane #(
    parameter int LANE_W = 8
) (
    input  logic [LANE_W-1:0] a_byte,
    input  logic [LANE_W-1:0] b_byte,
    output logic              same,
    output logic              a_nul
);
    // Per-lane compare; the zero test looks at operand A only.
    assign same  = ~|(a_byte ^ b_byte);
    assign a_nul = ~|a_byte;
endmodule

// File: rtl/vscan_elem_merge.sv
module vscan_elem_merge
    import vscan_pkg::*;
#(
    parameter int BYTES = 16
) (
    input  logic [BYTES-1:0] byte_same,
    input  logic [BYTES-1:0] byte_nul,
    input  esz_t             esz,
    output logic [BYTES-1:0] start_mask,
    output logic [BYTES-1:0] same_start,
    output logic [BYTES-1:0] nul_start
);
    // Each byte position k reports only when an element starts there.
    for (genvar k = 0; k < BYTES; k++) begin : g_pos
        logic h_s, h_e, h_z;
        logic w_s, w_e, w_z;
        logic s_k, e_k, z_k;

        if ((k % 2 == 0) && (k + 1 < BYTES)) begin : g_half
            assign h_s = 1'b1;
            assign h_e = &byte_same[k+1:k];
            assign h_z = &byte_nul[k+1:k];
        end else begin : g_nohalf
            assign h_s = 1'b0;
            assign h_e = 1'b0;
            assign h_z = 1'b0;
        end

        if ((k % 4 == 0) && (k + 3 < BYTES)) begin : g_word
            assign w_s = 1'b1;
            assign w_e = &byte_same[k+3:k];
            assign w_z = &byte_nul[k+3:k];
        end else begin : g_noword
            assign w_s = 1'b0;
            assign w_e = 1'b0;
            assign w_z = 1'b0;
        end

        always_comb begin
            unique case (esz)
                ESZ_BYTE: begin
                    s_k = 1'b1;
                    e_k = byte_same[k];
                    z_k = byte_nul[k];
                end
                ESZ_HALF: begin
                    s_k = h_s;
                    e_k = h_e;
                    z_k = h_z;
                end
                ESZ_WORD, ESZ_WALT: begin
                    s_k = w_s;
                    e_k = w_e;
                    z_k = w_z;
                end
                default: begin
                    s_k = 1'b0;
                    e_k = 1'b0;
                    z_k = 1'b0;
                end
            endcase
        end

        assign start_mask[k] = s_k;
        assign same_start[k] = e_k;
        assign nul_start[k]  = z_k;
    end
endmodule

// File: rtl/vscan_first_hit.sv
module vscan_first_hit #(
    parameter int BYTES = 16,
    parameter int IDX_W = $clog2(BYTES + 1)
) (
    input  logic [BYTES-1:0] hits,
    output logic [IDX_W-1:0] first
);
    // Lowest set position wins; BYTES means no bit set.
    always_comb begin
        first = IDX_W'(BYTES);
        for (int i = BYTES - 1; i >= 0; i--) begin
            if (hits[i]) begin
                first = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/vec_elem_scan.sv
module vec_elem_scan
    import vscan_pkg::*;
#(
    parameter int BYTES = 16,
    parameter int LANE_W = 8,
    parameter int IDX_W = $clog2(BYTES + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    input  logic [BYTES*LANE_W-1:0] vec_a,
    input  logic [BYTES*LANE_W-1:0] vec_b,
    input  logic [1:0]              elem_sz,
    input  logic                    want_diff,
    input  logic                    stop_on_nul,
    output logic                    res_valid,
    output logic [IDX_W-1:0]        res_idx,
    output logic [1:0]              res_cc
);
    localparam int VEC_W = BYTES * LANE_W;
    localparam logic [IDX_W-1:0] IDX_NONE = IDX_W'(BYTES);

    logic [BYTES-1:0] byte_same, byte_nul;
    logic [BYTES-1:0] start_mask, same_start, nul_start;
    logic [BYTES-1:0] hit_vec, term_vec;
    logic [IDX_W-1:0] hit_idx, term_idx;
    logic [IDX_W-1:0] nxt_idx;
    scan_cc_t         nxt_cc;
    scan_st_t         st_q, st_nxt;
    esz_t             esz;

    assign esz = esz_t'(elem_sz);

    // Byte 0 is the leftmost lane of each operand.
    for (genvar k = 0; k < BYTES; k++) begin : g_lane
        vscan_byte_lane #(.LANE_W(LANE_W)) i_lane (
            .a_byte (vec_a[VEC_W-1-LANE_W*k -: LANE_W]),
            .b_byte (vec_b[VEC_W-1-LANE_W*k -: LANE_W]),
            .same   (byte_same[k]),
            .a_nul  (byte_nul[k])
        );
    end

    vscan_elem_merge #(.BYTES(BYTES)) i_merge (
        .byte_same  (byte_same),
        .byte_nul   (byte_nul),
        .esz        (esz),
        .start_mask (start_mask),
        .same_start (same_start),
        .nul_start  (nul_start)
    );

    assign hit_vec  = want_diff ? (start_mask & ~same_start) : same_start;
    assign term_vec = stop_on_nul ? nul_start : '0;

    vscan_first_hit #(.BYTES(BYTES), .IDX_W(IDX_W)) i_hit_enc (
        .hits  (hit_vec),
        .first (hit_idx)
    );

    vscan_first_hit #(.BYTES(BYTES), .IDX_W(IDX_W)) i_term_enc (
        .hits  (term_vec),
        .first (term_idx)
    );

    // Terminator wins ties; nothing found reports the past-the-end index.
    always_comb begin
        if ((term_idx != IDX_NONE) && (term_idx <= hit_idx)) begin
            nxt_idx = term_idx;
            nxt_cc  = CC_NUL;
        end else if (hit_idx != IDX_NONE) begin
            nxt_idx = hit_idx;
            nxt_cc  = CC_MATCH;
        end else begin
            nxt_idx = IDX_NONE;
            nxt_cc  = CC_NONE;
        end
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_nxt;
        end
    end

    // Transitions: IDLE->SHOW and SHOW->SHOW on a request; otherwise back to IDLE.
    always_comb begin
        unique case (st_q)
            ST_IDLE: st_nxt = req_valid ? ST_SHOW : ST_IDLE;
            ST_SHOW: st_nxt = req_valid ? ST_SHOW : ST_IDLE;
            default: st_nxt = ST_IDLE;
        endcase
    end

    // Output registers: loaded on a request, held otherwise.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_idx <= IDX_NONE;
            res_cc  <= CC_NONE;
        end else if (req_valid) begin
            res_idx <= nxt_idx;
            res_cc  <= nxt_cc;
        end
    end

    assign res_valid = (st_q == ST_SHOW);

endmodule

// File: rtl/vscan_checker.sv
module vscan_checker #(
    parameter int BYTES = 16,
    parameter int IDX_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic [1:0]       elem_sz,
    input logic             stop_on_nul,
    input logic             res_valid,
    input logic [IDX_W-1:0] res_idx,
    input logic [1:0]       res_cc
);
    assert_valid_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> res_valid);

    assert_no_spurious_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !res_valid);

    assert_none_index_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_cc == 2'd3) |-> (res_idx == IDX_W'(BYTES)));

    assert_hit_in_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_cc != 2'd3) |-> (res_idx < IDX_W'(BYTES)));

    assert_cc_legal_R6: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (res_cc != 2'd2));

    assert_word_align_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && elem_sz[1]) |=> (res_cc == 2'd3 || res_idx[1:0] == 2'b00));

    assert_half_align_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && elem_sz == 2'b01) |=> (res_cc == 2'd3 || res_idx[0] == 1'b0));

    assert_nul_needs_enable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !stop_on_nul) |=> (res_cc != 2'd0));

    assert_hold_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> ($stable(res_idx) && $stable(res_cc)));
endmodule

bind vec_elem_scan vscan_checker #(.BYTES(BYTES), .IDX_W(IDX_W)) i_vscan_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .elem_sz     (elem_sz),
    .stop_on_nul (stop_on_nul),
    .res_valid   (res_valid),
    .res_idx     (res_idx),
    .res_cc      (res_cc)
);

// File: tb/test_vec_elem_scan.sv
`timescale 1ns/1ps
module test_vec_elem_scan;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic [127:0] vec_a = '0;
    logic [127:0] vec_b = '0;
    logic [1:0]   elem_sz = 2'b00;
    logic         want_diff = 1'b0;
    logic         stop_on_nul = 1'b0;
    logic         res_valid;
    logic [4:0]   res_idx;
    logic [1:0]   res_cc;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    vec_elem_scan i_vec_elem_scan (
        .clk (clk), .rst_n (rst_n), .req_valid (req_valid),
        .vec_a (vec_a), .vec_b (vec_b), .elem_sz (elem_sz),
        .want_diff (want_diff), .stop_on_nul (stop_on_nul),
        .res_valid (res_valid), .res_idx (res_idx), .res_cc (res_cc)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic [127:0] put(input [127:0] v, input int k, input [7:0] val);
        put = v;
        put[127-8*k -: 8] = val;
    endfunction

    // Operands with no equal bytes and no zero bytes.
    function automatic [127:0] base_a();
        base_a = '0;
        for (int k = 0; k < 16; k++) base_a = put(base_a, k, 8'h41 + 8'(k));
    endfunction
    function automatic [127:0] base_b();
        base_b = '0;
        for (int k = 0; k < 16; k++) base_b = put(base_b, k, 8'h90 + 8'(k));
    endfunction

    function automatic void model(input [127:0] a, input [127:0] b, input [1:0] sz,
                                  input bit nd, input bit zs,
                                  output int idx, output int cc);
        int w;
        bit found;
        w = (sz == 2'b00) ? 1 : (sz == 2'b01) ? 2 : 4;
        idx = 16; cc = 3; found = 0;
        for (int e = 0; e < 16; e += w) begin
            bit eq, z;
            eq = 1; z = 1;
            for (int j = 0; j < w; j++) begin
                if (a[127-8*(e+j) -: 8] != b[127-8*(e+j) -: 8]) eq = 0;
                if (a[127-8*(e+j) -: 8] != 8'h00) z = 0;
            end
            if (!found && zs && z) begin idx = e; cc = 0; found = 1; end
            if (!found && (nd ? !eq : eq)) begin idx = e; cc = 1; found = 1; end
        end
    endfunction

    task automatic run_case(input string req, input [127:0] a, input [127:0] b,
                            input [1:0] sz, input bit nd, input bit zs,
                            input int exp_idx, input int exp_cc);
        @(negedge clk);
        vec_a = a; vec_b = b; elem_sz = sz; want_diff = nd; stop_on_nul = zs;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check({req, " valid"}, int'(res_valid), 1);
        check({req, " idx"}, int'(res_idx), exp_idx);
        check({req, " cc"}, int'(res_cc), exp_cc);
    endtask

    task automatic t_reset();
        check("R8 reset valid", int'(res_valid), 0);
        check("R8 reset idx", int'(res_idx), 16);
        check("R8 reset cc", int'(res_cc), 3);
    endtask

    task automatic t_byte_equal();
        logic [127:0] a, b;
        a = base_a(); b = put(base_b(), 5, 8'h46);
        run_case("R3 R1 byte equal at 5", a, b, 2'b00, 0, 0, 5, 1);
        b = put(b, 0, 8'h41);
        run_case("R1 leftmost equal wins", a, b, 2'b00, 0, 0, 0, 1);
    endtask

    task automatic t_not_equal();
        logic [127:0] a;
        a = base_a();
        run_case("R3 diff at 9", a, put(a, 9, 8'hEE), 2'b00, 1, 1, 9, 1);
        run_case("R5 diff none", a, a, 2'b00, 1, 0, 16, 3);
    endtask

    task automatic t_terminator();
        logic [127:0] a, b;
        a = put(base_a(), 3, 8'h00);
        b = put(base_b(), 7, 8'h48);
        run_case("R4 nul before match", a, b, 2'b00, 0, 1, 3, 0);
        run_case("R4 nul ignored when off", a, b, 2'b00, 0, 0, 7, 1);
        run_case("R4 R6 match before nul", put(a, 3, 8'h44), put(b, 1, 8'h42), 2'b00, 0, 1, 1, 1);
        run_case("R4 nul only in b", base_a(), put(base_b(), 2, 8'h00), 2'b00, 0, 1, 16, 3);
    endtask

    task automatic t_tie();
        logic [127:0] a, b;
        a = put(base_a(), 4, 8'h00);
        b = put(base_b(), 4, 8'h00);
        run_case("R6 tie reports nul", a, b, 2'b00, 0, 1, 4, 0);
    endtask

    task automatic t_none();
        run_case("R5 nothing found", base_a(), base_b(), 2'b00, 0, 1, 16, 3);
    endtask

    task automatic t_half();
        logic [127:0] a, b;
        a = put(put(base_a(), 3, 8'h00), 4, 8'h00);
        b = put(base_b(), 6, 8'h47);
        b = put(put(b, 10, 8'h4B), 11, 8'h4C);
        run_case("R2 half aligned match", a, b, 2'b01, 0, 1, 10, 1);
        run_case("R2 half bytes straddle", a, put(base_b(), 7, 8'h48), 2'b01, 0, 1, 16, 3);
    endtask

    task automatic t_word();
        logic [127:0] a, b;
        a = base_a(); b = base_b();
        for (int k = 4; k < 7; k++) b = put(b, k, 8'h41 + 8'(k));
        for (int k = 8; k < 12; k++) b = put(b, k, 8'h41 + 8'(k));
        run_case("R2 word match sel 10", a, b, 2'b10, 0, 0, 8, 1);
        run_case("R2 word match sel 11", a, b, 2'b11, 0, 0, 8, 1);
        run_case("R2 R3 word diff", a, put(a, 13, 8'h01), 2'b10, 1, 0, 12, 1);
        run_case("R2 R4 word nul", put(put(put(put(a, 4, 0), 5, 0), 6, 0), 7, 0), b, 2'b10, 0, 1, 4, 0);
    endtask

    task automatic t_timing();
        logic [127:0] a;
        a = base_a();
        @(negedge clk);
        vec_a = a; vec_b = put(base_b(), 2, 8'h43); elem_sz = 2'b00;
        want_diff = 0; stop_on_nul = 0; req_valid = 1'b1;
        @(negedge clk);
        vec_b = put(base_b(), 12, 8'h4D);
        check("R7 first of pair valid", int'(res_valid), 1);
        check("R7 first of pair idx", int'(res_idx), 2);
        @(negedge clk);
        req_valid = 1'b0;
        check("R7 second of pair valid", int'(res_valid), 1);
        check("R7 second of pair idx", int'(res_idx), 12);
        vec_b = a;
        @(negedge clk);
        check("R7 idle drops valid", int'(res_valid), 0);
        check("R8 idle holds idx", int'(res_idx), 12);
        check("R8 idle holds cc", int'(res_cc), 1);
    endtask

    task automatic t_scatter();
        for (int n = 0; n < 40; n++) begin
            logic [127:0] a, b;
            logic [1:0] sz;
            bit nd, zs;
            int ei, ec;
            a = '0; b = '0;
            for (int k = 0; k < 16; k++) begin
                logic [7:0] x;
                x = 8'($urandom_range(0, 3));
                a = put(a, k, x);
                b = put(b, k, ($urandom_range(0, 1) == 1) ? x : 8'($urandom_range(0, 3)));
            end
            sz = 2'($urandom_range(0, 3));
            nd = 1'($urandom_range(0, 1));
            zs = 1'($urandom_range(0, 1));
            model(a, b, sz, nd, zs, ei, ec);
            run_case("R1 R3 R6 scatter", a, b, sz, nd, zs, ei, ec);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_byte_equal();
        t_not_equal();
        t_terminator();
        t_tie();
        t_none();
        t_half();
        t_word();
        t_timing();
        t_scatter();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule